// File: doc/BRIEF.md
# FIFO Threshold DMA Request Generator

This block drives the DMA request line for a small data FIFO that sits between a disk data path and a host DMA controller. It does not hold any data. It sees the FIFO occupancy as a count, and it tells the FIFO when the host moved a byte through one-cycle pop or push strobes. The transfer direction selects the trigger. Toward the host, the request fires once the FIFO has filled to within a programmable distance of full. Toward the disk, it fires once the FIFO has drained to a programmable level.

Two pacing styles are offered. In burst mode the request stays up until the FIFO is empty (reads) or full (writes). In non-burst mode the request drops after every byte and comes back after a fixed gap, which lets other DMA channels in. Sector boundaries override the threshold in both directions. On reads, a marker for the last disk byte of a sector forces the request so that the FIFO drains completely. On writes, an internal byte counter drops the request on the final byte of a sector and keeps it down until the next sector is enabled.

The acknowledge and the read and write strobes arrive from the host side without a clock relation to this block. Each one passes through a synchronizer, and byte transfers are found from their edges. A byte is counted in two cases: on the falling edge of the acknowledge, or, while the acknowledge is held low, on the rising edge of each further read or write strobe.

Top module: `dma_req_gen`

## Requirements
- R1: With `dir_read`=1, `drq` rises when `fifo_count` + `thresh` >= DEPTH (16 by default), unless a settling or gap period is running.
- R2: With `dir_read`=0 and a sector enabled, `drq` rises when `fifo_count` <= `thresh`; it never rises before the first `sector_enable` after reset.
- R3: With `burst_en`=1, `drq` stays high across byte transfers. It falls only after the byte that empties the FIFO (reads) or fills it (writes).
- R4: With `burst_en`=0, `drq` falls after every byte. If bytes remain (reads) or space remains (writes), it rises again exactly GAP_CYCLES+1 clock edges after the edge on which it fell.
- R5: A pulse on `sector_last` during reads forces `drq` while `fifo_count` is nonzero, whatever the threshold. The force is withdrawn once the FIFO has drained.
- R6: During writes, the transfer that completes SECTOR_BYTES pushes drops `drq` even if the FIFO is not full. `drq` then stays low until `sector_enable` pulses again.
- R7: A low pulse on `dack_n` counts as exactly one byte, whether or not a `rd_n` or `wr_n` strobe occurs inside it; a pulse with no strobe at all still pops a byte.
- R8: While `dack_n` stays low, the rising edge of every `rd_n`/`wr_n` strobe after the first counts as one further byte.
- R9: A qualifying pin edge applied before clock edge e1 releases `drq` on edge e3. This is two synchronizer stages plus one register.
- R10: Synchronous reset (`rst`=1) clears `drq`, `fifo_pop`, `fifo_push`, the gap counter and all sector state.
- R11: Each counted byte produces one `fifo_pop` pulse when `dir_read`=1 and one `fifo_push` pulse when `dir_read`=0, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_read | input | 1 | 1: disk-to-host, 0: host-to-disk |
| burst_en | input | 1 | 1: burst pacing, 0: one byte per request |
| thresh | input | TW (4) | Programmable threshold |
| fifo_count | input | CW (5) | Bytes currently held in the FIFO |
| sector_last | input | 1 | Pulse: last disk byte of the sector entered the FIFO |
| sector_enable | input | 1 | Pulse: arm writes for a new sector |
| dack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| drq | output | 1 | DMA request, registered |
| fifo_pop | output | 1 | One-cycle pop of a byte taken by the host |
| fifo_push | output | 1 | One-cycle push of a byte given by the host |

## Verification
The threshold is exercised just below and exactly at its trigger in both directions, which shows whether the comparison boundary is inclusive. Four acknowledge patterns are applied: a bare pulse, a pulse around a read strobe, a held acknowledge carrying several write strobes, and a strobe with no acknowledge. Comparing the resulting pop and push counts shows whether bytes are counted twice or dropped. In non-burst mode, the fall and the re-rise of the request are each sampled on their exact edge, so a different synchronizer depth or gap length shows up. In the sector tests, the FIFO count is left sitting inside the trigger range, which separates the sector overrides from plain threshold behaviour.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int PIN_W  = 3;
  localparam int PIN_DACK = 0;
  localparam int PIN_RD   = 1;
  localparam int PIN_WR   = 2;
  localparam int SETTLE_CYCLES = 2;

  function automatic int cnt_width(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '1;
    else     stage[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '1;
        else     stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/dreq_edge.sv
module dreq_edge (
  input  logic clk,
  input  logic rst,
  input  logic dack_s,
  input  logic rd_s,
  input  logic wr_s,
  output logic xfer
);
  logic dack_p, strb_p, fresh;
  logic strb, dack_fall, strb_rise;

  assign strb      = rd_s & wr_s;
  assign dack_fall = dack_p & ~dack_s;
  assign strb_rise = ~strb_p & strb;
  assign xfer      = dack_fall | (strb_rise & ~dack_s & ~fresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      dack_p <= 1'b1;
      strb_p <= 1'b1;
      fresh  <= 1'b0;
    end else begin
      dack_p <= dack_s;
      strb_p <= strb;
      if (dack_fall)                fresh <= 1'b1;
      else if (strb_rise || dack_s) fresh <= 1'b0;
    end
  end
endmodule

// File: rtl/dreq_sector.sv
module dreq_sector #(
  parameter int CW           = 5,
  parameter int SECTOR_BYTES = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_read,
  input  logic          sector_last,
  input  logic          sector_enable,
  input  logic          xfer,
  input  logic [CW-1:0] fifo_count,
  output logic          sec_pend,
  output logic          wr_armed,
  output logic          wr_last
);
  localparam int BW = dreq_pkg::cnt_width(SECTOR_BYTES);
  logic [BW-1:0] remain;

  assign wr_last = (remain == BW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_pend <= 1'b0;
      wr_armed <= 1'b0;
      remain   <= '0;
    end else begin
      if (sector_last)
        sec_pend <= 1'b1;
      else if (xfer && dir_read && fifo_count <= CW'(1))
        sec_pend <= 1'b0;

      if (sector_enable) begin
        wr_armed <= 1'b1;
        remain   <= BW'(SECTOR_BYTES);
      end else if (xfer && !dir_read && wr_armed) begin
        remain <= remain - BW'(1);
        if (wr_last) wr_armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dreq_core.sv
module dreq_core #(
  parameter int DEPTH      = 16,
  parameter int CW         = 5,
  parameter int TW         = 4,
  parameter int GAP_CYCLES = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_read,
  input  logic          burst_en,
  input  logic [TW-1:0] thresh,
  input  logic [CW-1:0] fifo_count,
  input  logic          xfer,
  input  logic          sec_pend,
  input  logic          wr_armed,
  input  logic          wr_last,
  output logic          drq,
  output logic          fifo_pop,
  output logic          fifo_push
);
  localparam int GAP_EFF = (GAP_CYCLES < dreq_pkg::SETTLE_CYCLES) ?
                           dreq_pkg::SETTLE_CYCLES : GAP_CYCLES;
  localparam int GW = dreq_pkg::cnt_width(GAP_EFF);
  localparam int SW = CW + 1;

  logic [GW-1:0] gap;
  logic          rearm;
  logic          trig_rd, trig_wr, trig, end_xfer;

  assign trig_rd  = ((SW'(fifo_count) + SW'(thresh)) >= SW'(DEPTH)) ||
                    (sec_pend && fifo_count != '0);
  assign trig_wr  = wr_armed && (fifo_count <= CW'(thresh)) &&
                    (fifo_count < CW'(DEPTH));
  assign trig     = dir_read ? trig_rd : trig_wr;
  assign end_xfer = dir_read ? (fifo_count <= CW'(1))
                             : (wr_last || fifo_count >= CW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      drq       <= 1'b0;
      gap       <= '0;
      rearm     <= 1'b0;
      fifo_pop  <= 1'b0;
      fifo_push <= 1'b0;
    end else begin
      fifo_pop  <= xfer & dir_read;
      fifo_push <= xfer & ~dir_read;
      if (xfer) begin
        if (burst_en && !end_xfer) begin
          drq <= drq;
        end else begin
          drq   <= 1'b0;
          rearm <= !burst_en && !end_xfer;
          gap   <= (!burst_en && !end_xfer) ? GW'(GAP_EFF)
                                            : GW'(dreq_pkg::SETTLE_CYCLES);
        end
      end else if (gap != '0) begin
        gap <= gap - GW'(1);
      end else if (!drq) begin
        if (rearm || trig) drq <= 1'b1;
        rearm <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
  parameter int DEPTH        = 16,
  parameter int CW           = $clog2(DEPTH + 1),
  parameter int TW           = $clog2(DEPTH),
  parameter int GAP_CYCLES   = 18,
  parameter int SECTOR_BYTES = 512,
  parameter int SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_read,
  input  logic          burst_en,
  input  logic [TW-1:0] thresh,
  input  logic [CW-1:0] fifo_count,
  input  logic          sector_last,
  input  logic          sector_enable,
  input  logic          dack_n,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic          drq,
  output logic          fifo_pop,
  output logic          fifo_push
);
  import dreq_pkg::*;

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic xfer, sec_pend, wr_armed, wr_last;

  always_comb begin
    pins_raw = '1;
    pins_raw[PIN_DACK] = dack_n;
    pins_raw[PIN_RD]   = rd_n;
    pins_raw[PIN_WR]   = wr_n;
  end

  dreq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pins_raw), .dout(pins_s)
  );

  dreq_edge u_edge (
    .clk(clk), .rst(rst),
    .dack_s(pins_s[PIN_DACK]), .rd_s(pins_s[PIN_RD]), .wr_s(pins_s[PIN_WR]),
    .xfer(xfer)
  );

  dreq_sector #(.CW(CW), .SECTOR_BYTES(SECTOR_BYTES)) u_sector (
    .clk(clk), .rst(rst), .dir_read(dir_read),
    .sector_last(sector_last), .sector_enable(sector_enable),
    .xfer(xfer), .fifo_count(fifo_count),
    .sec_pend(sec_pend), .wr_armed(wr_armed), .wr_last(wr_last)
  );

  dreq_core #(.DEPTH(DEPTH), .CW(CW), .TW(TW), .GAP_CYCLES(GAP_CYCLES)) u_core (
    .clk(clk), .rst(rst), .dir_read(dir_read), .burst_en(burst_en),
    .thresh(thresh), .fifo_count(fifo_count), .xfer(xfer),
    .sec_pend(sec_pend), .wr_armed(wr_armed), .wr_last(wr_last),
    .drq(drq), .fifo_pop(fifo_pop), .fifo_push(fifo_push)
  );
endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          dir_read,
  input logic          burst_en,
  input logic [CW-1:0] fifo_count,
  input logic          drq,
  input logic          fifo_pop,
  input logic          fifo_push
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!drq && !fifo_pop && !fifo_push)); // R10

  AST_NB_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!burst_en && $past(!burst_en) && (fifo_pop || fifo_push)) |-> !drq); // R4

  AST_NO_RISE_AT_XFER: assert property (@(posedge clk) disable iff (rst)
    $rose(drq) |-> !$past(fifo_pop || fifo_push)); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(fifo_pop && fifo_push)); // R11

  AST_POP_DIR: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> $past(dir_read)); // R11

  AST_RD_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (dir_read && $past(dir_read) && $rose(drq)) |-> (fifo_count != '0)); // R1
endmodule

bind dma_req_gen dma_req_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .dir_read(dir_read), .burst_en(burst_en),
  .fifo_count(fifo_count), .drq(drq), .fifo_pop(fifo_pop), .fifo_push(fifo_push)
);

// File: tb/dma_req_gen_bench.sv
module dma_req_gen_bench;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int CW     = 5;
  localparam int TW     = 4;
  localparam int GAP    = 8;
  localparam int SECT   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_read = 1'b1, burst_en = 1'b1;
  logic [TW-1:0] thresh = '0;
  logic [CW-1:0] cnt = '0;
  logic sector_last = 1'b0, sector_enable = 1'b0;
  logic dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic drq, fifo_pop, fifo_push;
  int checks = 0, errors = 0, pops = 0, pushes = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dma_req_gen #(.DEPTH(DEPTH), .GAP_CYCLES(GAP), .SECTOR_BYTES(SECT)) u_dma_req_gen (
    .clk(clk), .rst(rst), .dir_read(dir_read), .burst_en(burst_en),
    .thresh(thresh), .fifo_count(cnt), .sector_last(sector_last),
    .sector_enable(sector_enable), .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n),
    .drq(drq), .fifo_pop(fifo_pop), .fifo_push(fifo_push)
  );

  // FIFO occupancy model
  always @(posedge clk) begin
    if (fifo_pop)  begin cnt <= cnt - 1'b1; pops++;   end
    if (fifo_push) begin cnt <= cnt + 1'b1; pushes++; end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic rd, input logic bst, input int th);
    rst = 1'b1; dir_read = rd; burst_en = bst; thresh = TW'(th); cnt = '0;
    tick(3);
    rst = 1'b0; pops = 0; pushes = 0;
    tick(1);
  endtask

  task automatic dack_pulse(input bit with_rd);
    dack_n = 1'b0; tick(3);
    if (with_rd) begin rd_n = 1'b0; tick(2); rd_n = 1'b1; tick(3); end
    dack_n = 1'b1; tick(3);
  endtask

  task automatic t_reset;
    rst = 1'b1; tick(3);
    check("R10 drq in reset", drq, 0);
    check("R10 pop/push in reset", fifo_pop | fifo_push, 0);
  endtask

  task automatic t_read_thresh;
    do_reset(1, 1, 4);
    cnt = 11; tick(5);
    check("R1 below trigger", drq, 0);
    cnt = 12; tick(3);
    check("R1 at trigger", drq, 1);
  endtask

  task automatic t_write_thresh;
    do_reset(0, 0, 3);
    cnt = 3; tick(5);
    check("R2 not armed before sector_enable", drq, 0);
    cnt = 4;
    sector_enable = 1'b1; tick(1); sector_enable = 1'b0; tick(4);
    check("R2 above threshold", drq, 0);
    cnt = 3; tick(3);
    check("R2 at threshold", drq, 1);
  endtask

  task automatic t_burst_read;
    int low_seen = 0;
    do_reset(1, 1, 4);
    cnt = 12; tick(3);
    for (int i = 0; i < 11; i++) begin
      dack_pulse(0);
      if (!drq) low_seen++;
    end
    check("R3 drq held through burst", low_seen, 0);
    dack_pulse(0); tick(4);
    check("R3 drq falls at empty", drq, 0);
    check("R3 fifo drained", cnt, 0);
    check("R11 pops in burst", pops, 12);
  endtask

  task automatic t_nonburst_timing;
    do_reset(1, 0, 4);
    cnt = 12; tick(3);
    check("R1 nonburst trigger", drq, 1);
    dack_n = 1'b0;
    tick(2);
    check("R9 drq still up after edge e2", drq, 1);
    tick(1);
    check("R9 drq released on edge e3", drq, 0);
    dack_n = 1'b1;
    tick(GAP);
    check("R4 drq low through gap", drq, 0);
    tick(1);
    check("R4 drq re-raised after gap", drq, 1);
    check("R4 one byte popped", cnt, 11);
  endtask

  task automatic t_sector_read;
    do_reset(1, 1, 2);
    cnt = 3; tick(5);
    check("R5 below trigger before marker", drq, 0);
    sector_last = 1'b1; tick(1); sector_last = 1'b0; tick(3);
    check("R5 forced by sector end", drq, 1);
    for (int i = 0; i < 3; i++) dack_pulse(0);
    tick(4);
    check("R5 drained to empty", cnt, 0);
    check("R5 drq low when empty", drq, 0);
    cnt = 3; tick(6);
    check("R5 force withdrawn", drq, 0);
  endtask

  task automatic t_sector_write;
    do_reset(0, 1, 15);
    sector_enable = 1'b1; tick(1); sector_enable = 1'b0; tick(4);
    check("R2 write trigger when empty", drq, 1);
    dack_n = 1'b0; tick(3);
    for (int i = 0; i < SECT; i++) begin
      wr_n = 1'b0; tick(2); wr_n = 1'b1; tick(3);
    end
    dack_n = 1'b1; tick(4);
    check("R8 pushes with held acknowledge", pushes, SECT);
    check("R11 no pops on write", pops, 0);
    check("R6 drq low at sector end", drq, 0);
    tick(20);
    check("R6 drq held off until next sector", drq, 0);
    sector_enable = 1'b1; tick(1); sector_enable = 1'b0; tick(4);
    check("R6 re-armed by sector_enable", drq, 1);
  endtask

  task automatic t_strobes;
    do_reset(1, 1, 4);
    cnt = 12; tick(3);
    dack_pulse(1); tick(2);
    check("R7 pulse with read strobe pops one", cnt, 11);
    dack_pulse(0); tick(2);
    check("R7 bare pulse pops one", cnt, 10);
    rd_n = 1'b0; tick(2); rd_n = 1'b1; tick(5);
    check("R7 strobe without acknowledge ignored", cnt, 10);
  endtask

  initial begin
    t_reset();
    t_read_thresh();
    t_write_thresh();
    t_burst_read();
    t_nonburst_timing();
    t_sector_read();
    t_sector_write();
    t_strobes();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule